// File: doc/BRIEF.md
# Six-Channel DMA Burst Arbiter

This block decides which of six identical DMA channels may run its next burst. Each channel raises a request line while it has work. The arbiter answers with a one-hot grant. A grant stays in place until the active channel signals that its burst has ended, because a burst is never split. At that boundary the arbiter picks the next channel. When no channel is requesting, the grant falls to zero.

In the normal mode, the channels share the engine in a rotation. The search starts from the channel after the last one served, and channels that are not requesting are passed over at no cost. A mode input gives channel 1 precedence. While the mode is on, a pending channel 1 request takes the next burst boundary. The rotation pointer is left untouched during that service. After the channel 1 service ends, the rotation resumes from the saved point, after one idle cycle spent restoring it.

The block also relays completion interrupts. Each channel has its own interrupt line. A channel's line pulses when that channel ends a burst that was the last burst of its transfer.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, `grant` and `irq` are all zero and the rotation pointer is at channel 1 (index 0), so channel 1 is searched first.
- R2: `grant` is one-hot or zero. A newly issued grant always goes to a channel whose request bit was high at the clock edge that issued it.
- R3: Once issued, a grant stays unchanged until `burst_done` is sampled high, even if the granted channel drops its request.
- R4: In the rotation, a grant issued at a boundary goes to the first requesting channel found by searching upward, with wrap, from the channel after the last one the rotation granted. Non-requesting channels are skipped, so consecutive bursts follow each other with no idle cycle.
- R5: With no request pending, `grant` is zero and the pointer keeps its value. A later grant continues the rotation from where it stopped.
- R6: A `burst_done` pulse while nothing is granted has no effect. `grant` stays zero and no `irq` bit rises.
- R7: With `hi_prio_en` high, a pending channel 1 request (bit 0 of `req`) wins every arbitration slot, ahead of the rotation.
- R8: A grant won through the channel 1 precedence leaves the rotation pointer unchanged, so the interrupted rotation resumes where it stopped.
- R9: When a channel 1 precedence burst ends and the next winner is another channel, `grant` is zero for exactly one cycle before that winner. When channel 1 wins again, no gap is inserted.
- R10: `irq[i]` is high for exactly one cycle, namely the cycle after an edge where `burst_done` and `xfer_end` are both high while channel i holds the grant. Otherwise it is low.
- R11: With `hi_prio_en` low, channel 1 is an ordinary member of the rotation and gets no precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_prio_en | input | 1 | Gives channel 1 precedence over the rotation |
| req | input | 6 | Per-channel pending request; bit 0 is channel 1 |
| burst_done | input | 1 | The granted channel's burst ends this cycle |
| xfer_end | input | 1 | With `burst_done`: that burst closed the channel's transfer |
| grant | output | 6 | One-hot grant, zero when idle or restoring |
| irq | output | 6 | Per-channel transfer-complete pulse |

## Verification
The bench builds the arbiter with its default of six channels and drives every burst for three cycles. Six channels are enough to exercise pointer wrap-around, runs of skipped channels, and the case where channel 1 both interrupts a rotation and later competes inside it. The three-cycle burst leaves room to raise channel 1 in the middle of another channel's burst. It also lets a request drop while a grant is still held.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // default channel count and the channel that may take precedence
  localparam int CH_COUNT = 6;
  localparam int HP_CH    = 0;

  // channel that follows idx in the rotation
  function automatic int wrap_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // channel reached by moving off steps up from base, with wrap
  function automatic int rot_index(input int base, input int off, input int n);
    int s;
    s = base + off;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/dma_rr_picker.sv
module dma_rr_picker
  import dma_arb_pkg::*;
#(
  parameter int N = CH_COUNT
) (
  input  logic [N-1:0]         req,
  input  logic [$clog2(N)-1:0] start,
  output logic                 found,
  output logic [$clog2(N)-1:0] pick
);
  localparam int IW = $clog2(N);

  // request vector rotated so that bit 0 is the search start
  logic [N-1:0] rot_req;

  generate
    for (genvar k = 0; k < N; k++) begin : g_rot
      always_comb rot_req[k] = req[rot_index(int'(start), k, N)];
    end
  endgenerate

  // first set bit of the rotated vector, mapped back to a channel
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot_req[k]) begin
        found = 1'b1;
        pick  = IW'(rot_index(int'(start), k, N));
      end
    end
  end

endmodule

// File: rtl/dma_prio_select.sv
module dma_prio_select
  import dma_arb_pkg::*;
#(
  parameter int N = CH_COUNT
) (
  input  logic                 hp_mode,
  input  logic [N-1:0]         req,
  input  logic                 rr_found,
  input  logic [$clog2(N)-1:0] rr_pick,
  output logic                 win_valid,
  output logic [$clog2(N)-1:0] win_idx,
  output logic                 win_hp
);
  localparam int IW = $clog2(N);

  logic hp_take;
  assign hp_take = hp_mode && req[HP_CH];

  always_comb begin
    win_hp    = hp_take;
    win_valid = hp_take || rr_found;
    win_idx   = hp_take ? IW'(HP_CH) : rr_pick;
  end

endmodule

// File: rtl/dma_irq_relay.sv
module dma_irq_relay
  import dma_arb_pkg::*;
#(
  parameter int N = CH_COUNT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         burst_done,
  input  logic         xfer_end,
  input  logic [N-1:0] grant,
  output logic [N-1:0] irq
);
  logic closing;
  assign closing = burst_done && xfer_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= '0;
    else        irq <= closing ? grant : '0;
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      // R10: the owner's closing burst raises its line one cycle later
      assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (closing && grant[i]) |=> irq[i]);
      // R10: a line stays low without its own closing burst
      assert_irq_only_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(closing && grant[i]) |=> !irq[i]);
    end
  endgenerate

  assert_irq_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = CH_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_prio_en,
  input  logic [NUM_CH-1:0] req,
  input  logic              burst_done,
  input  logic              xfer_end,
  output logic [NUM_CH-1:0] grant,
  output logic [NUM_CH-1:0] irq
);
  localparam int IW = $clog2(NUM_CH);

  logic [NUM_CH-1:0] grant_q;
  logic              hp_q;      // current grant came through the precedence
  logic              resume_q;  // restore cycle after a precedence burst
  logic [IW-1:0]     ptr_q;     // rotation search start

  logic          rr_found;
  logic [IW-1:0] rr_pick;
  logic          win_valid;
  logic [IW-1:0] win_idx;
  logic          win_hp;

  // named events used by the logic and the assertions
  logic active;
  logic arb_slot;
  logic resume_bubble;
  assign active        = (grant_q != '0);
  assign arb_slot      = !active || burst_done;
  assign resume_bubble = burst_done && active && hp_q && !win_hp;

  dma_rr_picker #(.N(NUM_CH)) u_picker (
    .req   (req),
    .start (ptr_q),
    .found (rr_found),
    .pick  (rr_pick)
  );

  dma_prio_select #(.N(NUM_CH)) u_select (
    .hp_mode   (hi_prio_en),
    .req       (req),
    .rr_found  (rr_found),
    .rr_pick   (rr_pick),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_hp    (win_hp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q  <= '0;
      hp_q     <= 1'b0;
      resume_q <= 1'b0;
      ptr_q    <= '0;
    end else begin
      resume_q <= 1'b0;
      if (arb_slot) begin
        if (resume_bubble) begin
          grant_q  <= '0;
          hp_q     <= 1'b0;
          resume_q <= 1'b1;
        end else if (win_valid) begin
          grant_q <= NUM_CH'(1) << win_idx;
          hp_q    <= win_hp;
          if (!win_hp) ptr_q <= IW'(wrap_next(int'(win_idx), NUM_CH));
        end else begin
          grant_q <= '0;
          hp_q    <= 1'b0;
        end
      end
    end
  end

  assign grant = grant_q;

  dma_irq_relay #(.N(NUM_CH)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_done (burst_done),
    .xfer_end   (xfer_end),
    .grant      (grant_q),
    .irq        (irq)
  );

  // R2: never more than one channel granted
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));
  // R2: a new grant goes to a channel that was requesting
  assert_grant_to_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(grant_q) && grant_q != '0) |-> (($past(req) & grant_q) != '0));
  // R4: the rotation choice is a requesting channel
  assert_pick_requests_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rr_found |-> req[rr_pick]);
  // R3: a grant is held until its burst ends
  assert_hold_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !burst_done) |=> $stable(grant_q));
  // R5: idle with no requests keeps grant zero and the pointer still
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && req == '0) |=> (grant_q == '0 && $stable(ptr_q)));
  // R7: channel 1 takes any slot while precedence is on
  assert_hp_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_slot && hi_prio_en && req[HP_CH]) |=> grant_q[HP_CH]);
  // R8: precedence service does not move the rotation pointer
  assert_ptr_saved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hp_q |=> $stable(ptr_q));
  // R9: leaving a precedence burst for another channel costs one idle cycle
  assert_resume_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && active && hp_q && !(hi_prio_en && req[HP_CH])) |=> (grant_q == '0 && resume_q));
  // R9: the restore cycle lasts one cycle only
  assert_resume_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |=> !resume_q);

endmodule

// File: tb/dma_prio_arbiter_test.sv
module dma_prio_arbiter_test;
  localparam int N    = 6;
  localparam int BLEN = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hi_prio_en = 1'b0;
  logic         burst_done = 1'b0;
  logic         xfer_end = 1'b0;
  logic [N-1:0] req = '0;
  wire  [N-1:0] grant;
  wire  [N-1:0] irq;

  always #4 clk = ~clk;  // 125 MHz

  dma_prio_arbiter #(.NUM_CH(N)) uut (
    .clk(clk), .rst_n(rst_n), .hi_prio_en(hi_prio_en), .req(req),
    .burst_done(burst_done), .xfer_end(xfer_end), .grant(grant), .irq(irq)
  );

  typedef struct { int ch; int gap; string tag; } exp_t;
  exp_t q[$];

  int errors = 0;
  int checks = 0;
  int remaining [N];
  logic [N-1:0] prev_g = '0;
  logic         prev_done = 1'b0;
  logic [N-1:0] exp_irq = '0;
  int  cnt = 0;
  int  zero_run = 0;
  bit  held_ok = 1'b1;
  bit  force_stray = 1'b0;
  bit  stray_chk = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int idx_of(input logic [N-1:0] v);
    int r = -1;
    for (int i = 0; i < N; i++) if (v[i]) r = i;
    return r;
  endfunction

  // monitor (scoreboard side) followed by the channel responder
  always @(negedge clk) begin
    bit start;
    int gch;
    if (rst_n) begin
      if (irq != '0 || exp_irq != '0 || stray_chk)
        check(irq == exp_irq, "R10", "irq lines", int'(irq), int'(exp_irq));
      stray_chk = 1'b0;
      exp_irq = '0;
      if (prev_g != '0 && !prev_done && grant != prev_g) held_ok = 1'b0;
      if (prev_done) check(held_ok, "R3", "grant held through burst", 0, 1);
      start = (grant != '0) && (prev_g == '0 || prev_done);
      gch = idx_of(grant);
      if (start) begin
        if (q.size() == 0) check(1'b0, "R4", "unexpected grant", gch, -1);
        else begin
          exp_t e;
          e = q.pop_front();
          check(gch == e.ch, e.tag, "granted channel", gch, e.ch);
          if (e.gap >= 0) check(zero_run == e.gap, e.tag, "idle cycles before grant", zero_run, e.gap);
        end
        cnt = 0;
        held_ok = 1'b1;
        if (remaining[gch] == 1) req[gch] = 1'b0;  // drop request while granted
      end
      if (grant == '0) zero_run++;
      burst_done = 1'b0;
      xfer_end = 1'b0;
      if (grant != '0) begin
        cnt++;
        if (cnt == BLEN) begin
          burst_done = 1'b1;
          xfer_end = (remaining[gch] == 1);
          if (xfer_end) exp_irq = grant;
          remaining[gch]--;
          zero_run = 0;
        end
      end else if (force_stray) begin
        burst_done = 1'b1;
        xfer_end = 1'b1;
        force_stray = 1'b0;
        stray_chk = 1'b1;
      end
      prev_done = burst_done && (grant != '0);
      prev_g = grant;
    end
  end

  task automatic expect_grant(input int ch, input int gap, input string tag);
    exp_t e;
    e.ch = ch; e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic post(input int ch, input int n);
    remaining[ch] = n;
    req[ch] = 1'b1;
  endtask

  task automatic drain();
    do @(posedge clk); while (!(q.size() == 0 && req == '0 && grant == '0));
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) remaining[i] = 0;
    repeat (3) @(posedge clk);
    #2;
    check(grant == '0, "R1", "grant in reset", int'(grant), 0);
    check(irq == '0, "R1", "irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check(grant == '0, "R1", "grant after reset", int'(grant), 0);

    // R1 R4 R11: all channels, rotation from channel 1 upward
    for (int i = 0; i < N; i++) expect_grant(i, (i == 0) ? -1 : 0, "R4");
    for (int i = 0; i < N; i++) post(i, 1);
    drain();

    // R4: wrap from channel 6 to 1 with skipped channels
    expect_grant(0, -1, "R4"); expect_grant(2, 0, "R4");
    expect_grant(0, 0, "R4");  expect_grant(2, 0, "R4");
    post(0, 2); post(2, 2);
    drain();

    // R5: idle keeps grant zero
    repeat (5) @(posedge clk);
    #2;
    check(grant == '0, "R5", "grant while idle", int'(grant), 0);
    // R6: stray burst_done while idle
    force_stray = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(grant == '0, "R6", "grant after stray done", int'(grant), 0);
    // R5: pointer held at channel 4 (index 3)
    expect_grant(4, -1, "R5"); expect_grant(1, 0, "R5");
    post(1, 1); post(4, 1);
    drain();

    // R7 R8 R9: channel 1 cuts into a rotation
    hi_prio_en = 1'b1;
    expect_grant(3, -1, "R4"); expect_grant(0, 0, "R7");
    expect_grant(4, 1, "R9");  expect_grant(3, 0, "R8");
    expect_grant(4, 0, "R8");
    post(3, 2); post(4, 2);
    while (grant != 6'b001000) @(posedge clk);
    #2;
    post(0, 1);
    drain();

    // R7 R9: channel 1 twice without a gap, then a gap before channel 6
    expect_grant(0, -1, "R7"); expect_grant(0, 0, "R9");
    expect_grant(5, 1, "R9");
    post(0, 2); post(5, 1);
    drain();

    // R11: no precedence with the mode off
    hi_prio_en = 1'b0;
    expect_grant(2, -1, "R4");
    post(2, 1);
    drain();
    expect_grant(4, -1, "R11"); expect_grant(0, 0, "R11");
    post(0, 1); post(4, 1);
    drain();

    check(q.size() == 0, "R4", "expected grants left", q.size(), 0);
    summary();
    $finish;
  end

endmodule